// File: doc/BRIEF.md
# Clocked Serial Transceiver with Start Detection

This block is a synchronous serial shift port. It has a clock line, a receive data line and a transmit data line. It can drive the serial clock itself (master), using a simple system-clock divider, or it can follow a clock from outside (slave). Each transfer moves 1 to 8 bits in each direction at once. Software chooses the length and whether the least or the most significant bit goes first. When a transfer ends, the received word is copied into a one-byte receive holding register, a ready flag is raised and a one-cycle completion pulse is produced.

In slave mode the port pays attention to the outside clock only while a transfer is active. A transfer is armed by writing the transmit register. It can also be armed by a start condition, which is a falling edge on the receive data line while the clock sits at a selectable level. A start condition that arrives during a transfer starts the bit count again and marks the pending transmit byte as stale. The port then sends ones until software writes the transmit register again.

Software uses a small register port: four addresses, a write strobe, and a read strobe whose data comes back one clock later.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, sdo and sclk_out are 1, irq_done is 0, the status register (address 3) reads 0x00 and the setup register (address 0) reads 0x07.
- R2: The setup register at address 0 has these fields: bits [2:0] length code (bits per transfer = code+1), bit 3 MSB-first, bit 4 master, bit 5 start-condition enable, bit 6 start clock level. The register resets to length code 7 and keeps each written value until the next write to address 0.
- R3: In master mode, a write to address 1 starts a transfer. sclk_out idles high. sdo changes on each falling edge of sclk_out, and sdi is sampled on each rising edge. With bit 3 clear, bit k of the transmit byte is sent k-th, and the k-th received bit lands in bit k of the receive register (address 2).
- R4: With bit 3 set, a transfer of N bits sends transmit bit N-1 first. The received bits are packed in order of arrival into the low N bits, so the first bit lands in bit N-1 and the unused upper bits read 0.
- R5: Status bit 0 (receive ready) becomes 1 when the receive register is loaded at the end of a transfer. It becomes 0 when address 2 is read.
- R6: The receive register is overwritten at every completed transfer, even if it has not been read.
- R7: irq_done is a single-cycle pulse, given once per completed transfer. In master mode it is high in the cycle in which sclk_out first shows the final rising edge. In slave mode it rises three system clocks after the final rising edge of sclk_in.
- R8: In slave mode with no transfer active, toggling sclk_in has no effect: irq_done stays 0 and the status busy bit (bit 1) stays 0.
- R9: In slave mode, a write to address 1 arms a transfer that follows sclk_in. Transmit bits are shifted out on its falling edges and receive bits are sampled on its rising edges.
- R10: With bit 5 clear, a falling edge on sdi never arms or restarts a transfer.
- R11: With bit 5 set in slave mode, a falling edge on sdi is a start condition only if sclk_in is at the qualifying level: high when bit 6 is 0, low when bit 6 is 1. A start condition arms a transfer when the port is idle.
- R12: A start condition during a transfer restarts the bit count, so a full programmed length follows it. The pending transmit byte becomes invalid, and sdo is then 1 for every bit until the transmit register is written again. sdo is 1 whenever no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 setup, 1 transmit, 2 receive, 3 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_done | output | 1 | Transfer completion pulse |
| sclk_in | input | 1 | Serial clock from outside (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode), idles high |
| sdi | input | 1 | Serial receive data line |
| sdo | output | 1 | Serial transmit data line |

## Verification
The embedded assertions are checked on every cycle. They cover the single-cycle shape of the completion pulse, the setting and clearing of the ready flag, the receive register taking the engine's word on completion, the setup register staying unchanged without a write, and sclk_out and sdo idling high. Bit order, the alignment of short words, slave-clock masking, the level qualifier of the start condition and the restart with stale transmit data only show in the bench's scenarios. In those, a behavioural model drives the serial lines and compares sdo and irq_done cycle by cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned LW = $clog2(DW);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_RX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // Setup register fields, packed from bit 6 down to bit 0
  typedef struct packed {
    logic          start_lvl;  // 0: clock high qualifies, 1: clock low
    logic          start_en;
    logic          master;
    logic          msb_first;
    logic [LW-1:0] len;        // bits per transfer minus one
  } cfg_t;
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  input  logic          start_det,
  output cfg_t          cfg,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          tx_arm,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] CFG_RST = DW'(7);

  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rx_buf;
  logic          rx_full;

  assign cfg    = cfg_t'(cfg_q[$bits(cfg_t)-1:0]);
  assign tx_arm = wr && (addr == ADDR_TX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RST;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      rx_buf   <= '0;
      rx_full  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr && addr == ADDR_CFG) cfg_q <= wdata;
      if (start_det || done) tx_valid <= 1'b0;
      if (tx_arm) begin
        tx_data  <= wdata;
        tx_valid <= 1'b1;
      end
      if (rd && addr == ADDR_RX) rx_full <= 1'b0;
      if (done) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end
      if (rd) begin
        case (addr)
          ADDR_CFG:  rdata <= cfg_q;
          ADDR_TX:   rdata <= tx_data;
          ADDR_RX:   rdata <= rx_buf;
          default:   rdata <= {{(DW-2){1'b0}}, busy, rx_full};
        endcase
      end
    end
  end

  // R5: ready flag follows completion and read
  a_r5_full_on_done: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_full);
  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == ADDR_RX && !done) |=> !rx_full);
  // R6: holding register takes every completed word
  a_r6_buf_overwrite: assert property (@(posedge clk) disable iff (rst)
    done |=> (rx_buf == $past(rx_word)));
  // R2: setup retained without a write
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == ADDR_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdi,
  input  logic busy,
  input  logic slave,
  input  logic start_en,
  input  logic start_lvl,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s,
  output logic start_det
);
  logic [STAGES-1:0] sck_ff;
  logic [STAGES-1:0] sdi_ff;
  logic              sck_s, sck_m, sck_prev, sdi_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_ff <= '1;
          sdi_ff <= '1;
        end else begin
          sck_ff <= sclk_in;
          sdi_ff <= sdi;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_ff <= '1;
          sdi_ff <= '1;
        end else begin
          sck_ff <= {sck_ff[STAGES-2:0], sclk_in};
          sdi_ff <= {sdi_ff[STAGES-2:0], sdi};
        end
      end
    end
  endgenerate

  assign sck_s = sck_ff[STAGES-1];
  assign sdi_s = sdi_ff[STAGES-1];
  // outside clock is held at its idle level unless a transfer runs
  assign sck_m = busy ? sck_s : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b1;
      sdi_prev <= 1'b1;
    end else begin
      sck_prev <= sck_m;
      sdi_prev <= sdi_s;
    end
  end

  assign sclk_fall = slave && busy && sck_prev && !sck_m;
  assign sclk_rise = slave && busy && !sck_prev && sck_m;
  assign start_det = slave && start_en && sdi_prev && !sdi_s &&
                     (sck_s == !start_lvl);
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_out,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TC = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          tc;

  assign tc   = run && (cnt == TC);
  assign fall = tc && sclk_out;
  assign rise = tc && !sclk_out;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      sclk_out <= 1'b1;
    end else if (tc) begin
      cnt      <= '0;
      sclk_out <= !sclk_out;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: generated clock idles high
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> sclk_out);
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  cfg_t          cfg,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          arm,
  input  logic          start_det,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_s,
  output logic          busy,
  output logic          sdo,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  logic [LW-1:0] cnt;
  logic [LW-1:0] idx;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] rx_nxt;

  assign idx = cfg.msb_first ? (cfg.len - cnt) : cnt;

  always_comb begin
    rx_nxt = rx_sr;
    if (cfg.msb_first) rx_nxt = {rx_sr[DW-2:0], sdi_s};
    else               rx_nxt[cnt] = sdi_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
      sdo     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sdo <= 1'b1;
        if (arm || start_det) begin
          busy  <= 1'b1;
          cnt   <= '0;
          rx_sr <= '0;
        end
      end else if (start_det) begin
        cnt   <= '0;
        rx_sr <= '0;
      end else if (sclk_fall) begin
        sdo <= tx_valid ? tx_data[idx] : 1'b1;
      end else if (sclk_rise) begin
        rx_sr <= rx_nxt;
        if (cnt == cfg.len) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= rx_nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: completion is a lone pulse and closes the transfer
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R12: transmit line idles high
  a_r12_sdo_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> sdo);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssp_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_done,
  input  logic       sclk_in,
  output logic       sclk_out,
  input  logic       sdi,
  output logic       sdo
);
  cfg_t          cfg;
  logic [DW-1:0] tx_data, rx_word;
  logic          tx_valid, tx_arm, busy, done, start_det, sdi_s;
  logic          s_rise, s_fall, m_rise, m_fall, rise, fall;

  ssp_regs u_regs (
    .clk, .rst, .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .busy, .done, .rx_word, .start_det, .cfg, .tx_data, .tx_valid, .tx_arm,
    .rdata(reg_rdata)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .sclk_in, .sdi, .busy, .slave(!cfg.master),
    .start_en(cfg.start_en), .start_lvl(cfg.start_lvl),
    .sclk_rise(s_rise), .sclk_fall(s_fall), .sdi_s, .start_det
  );

  ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk, .rst, .run(busy && cfg.master), .sclk_out, .rise(m_rise), .fall(m_fall)
  );

  assign rise = cfg.master ? m_rise : s_rise;
  assign fall = cfg.master ? m_fall : s_fall;

  ssp_engine u_engine (
    .clk, .rst, .cfg, .tx_data, .tx_valid, .arm(tx_arm), .start_det,
    .sclk_rise(rise), .sclk_fall(fall), .sdi_s, .busy, .sdo, .done, .rx_word
  );

  assign irq_done = done;
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int H = 8;

  logic       clk = 1'b0, rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_done, sclk_out, sdo;
  logic       sclk_in = 1'b1, sdi = 1'b1;
  int         vectors = 0, miss = 0;
  bit         finished = 1'b0;

  sync_serial_xcvr u_sync_serial_xcvr (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .irq_done, .sclk_in, .sclk_out, .sdi, .sdo
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every cycle: compare the completion pulse with the model
  task automatic tick(input bit exp_irq);
    @(negedge clk);
    chk(irq_done === exp_irq, "R7", "irq_done", irq_done, exp_irq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1'b0);
    reg_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp,
                            input string req);
    reg_addr = a; reg_rd = 1'b1;
    tick(1'b0);
    reg_rd = 1'b0;
    chk(reg_rdata === exp, req, "register read", reg_rdata, exp);
  endtask

  function automatic logic pick(input logic [7:0] w, input int n,
                                input int k, input bit msb);
    return msb ? w[n-1-k] : w[k];
  endfunction

  task automatic master_xfer(input int n, input logic [7:0] v,
                             input logic [7:0] txb, input bit msb,
                             input string req);
    logic prev, cur;
    int   k = 0, guard = 0;
    wr_reg(2'd1, txb);
    prev = sclk_out;
    while (k < n && guard < 2000) begin
      @(negedge clk);
      guard++;
      cur = sclk_out;
      if (prev && !cur) sdi = pick(v, n, k, msb);
      if (!prev && cur) begin
        chk(sdo === pick(txb, n, k, msb), req, "sdo bit", sdo, pick(txb, n, k, msb));
        chk(irq_done === (k == n-1), "R7", "irq on final rise", irq_done, k == n-1);
        k++;
      end else begin
        chk(irq_done === 1'b0, "R7", "irq_done", irq_done, 0);
      end
      prev = cur;
    end
    chk(k == n, req, "master bit count", k, n);
    idle(3);
  endtask

  task automatic slave_clock(input int n, input logic [7:0] v,
                             input logic [7:0] txb, input bit txok,
                             input bit msb, input bit first_low,
                             input bit fin, input string req);
    for (int k = 0; k < n; k++) begin
      if (!(first_low && k == 0)) begin
        sclk_in = 1'b0;
        sdi = pick(v, n, k, msb);
        idle(H);
        chk(sdo === (txok ? pick(txb, n, k, msb) : 1'b1), req, "slave sdo",
            sdo, txok ? pick(txb, n, k, msb) : 1'b1);
      end
      sclk_in = 1'b1;
      for (int j = 0; j < H; j++) tick(fin && k == n-1 && j == 2);
    end
  endtask

  task automatic start_seq(input logic lvl);
    sclk_in = lvl;
    idle(4);
    sdi = 1'b1;
    idle(4);
    sdi = 1'b0;
    idle(5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(1'b0);
    // R1 reset state
    chk(sdo === 1'b1, "R1", "sdo", sdo, 1);
    chk(sclk_out === 1'b1, "R1", "sclk_out", sclk_out, 1);
    expect_reg(2'd0, 8'h07, "R1");
    expect_reg(2'd3, 8'h00, "R1");

    // R2 setup retained, R3 master LSB-first
    wr_reg(2'd0, 8'h17);
    expect_reg(2'd0, 8'h17, "R2");
    master_xfer(8, 8'h3C, 8'hA5, 1'b0, "R3");
    expect_reg(2'd3, 8'h01, "R5");
    expect_reg(2'd2, 8'h3C, "R3");
    expect_reg(2'd3, 8'h00, "R5");

    // R4 MSB-first, 5 bits
    wr_reg(2'd0, 8'h1C);
    master_xfer(5, 8'h0B, 8'h16, 1'b1, "R4");
    expect_reg(2'd2, 8'h0B, "R4");
    expect_reg(2'd0, 8'h1C, "R2");

    // R6 overwrite without reading
    wr_reg(2'd0, 8'h12);
    master_xfer(3, 8'h05, 8'h06, 1'b0, "R3");
    master_xfer(3, 8'h02, 8'h01, 1'b0, "R3");
    expect_reg(2'd3, 8'h01, "R5");
    expect_reg(2'd2, 8'h02, "R6");

    // one-bit transfer
    wr_reg(2'd0, 8'h10);
    master_xfer(1, 8'h01, 8'h00, 1'b0, "R3");
    expect_reg(2'd2, 8'h01, "R3");

    // R8 slave clock masked while idle
    wr_reg(2'd0, 8'h07);
    for (int c = 0; c < 3; c++) begin
      sclk_in = 1'b0; idle(H);
      sclk_in = 1'b1; idle(H);
    end
    expect_reg(2'd3, 8'h00, "R8");

    // R9 slave armed by transmit write
    wr_reg(2'd1, 8'hC3);
    idle(6);
    expect_reg(2'd3, 8'h02, "R9");
    slave_clock(8, 8'h96, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    expect_reg(2'd2, 8'h96, "R9");

    // R10 start disabled
    start_seq(1'b1);
    expect_reg(2'd3, 8'h00, "R10");

    // R11 level 0: low clock ignored, high clock arms
    wr_reg(2'd0, 8'h27);
    start_seq(1'b0);
    expect_reg(2'd3, 8'h00, "R11");
    start_seq(1'b1);
    expect_reg(2'd3, 8'h02, "R11");
    slave_clock(8, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R12");
    expect_reg(2'd2, 8'h5A, "R11");

    // R11 level 1: low clock arms a 1-bit transfer
    wr_reg(2'd0, 8'h60);
    start_seq(1'b0);
    expect_reg(2'd3, 8'h02, "R11");
    slave_clock(1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
    expect_reg(2'd2, 8'h00, "R11");

    // R12 restart mid-transfer invalidates transmit data
    wr_reg(2'd0, 8'h27);
    wr_reg(2'd1, 8'h00);
    idle(6);
    slave_clock(3, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R12");
    start_seq(1'b1);
    expect_reg(2'd3, 8'h02, "R12");
    slave_clock(8, 8'hB2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R12");
    expect_reg(2'd2, 8'hB2, "R12");
    chk(sdo === 1'b1, "R12", "sdo idle", sdo, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end
endmodule